// File: doc/BRIEF.md
# Palette and Geometry Register File

This block is the control-register slave of an indexed-colour framebuffer controller. It sits on a byte-addressed write bus and holds two things: a 256-entry colour lookup table of 24-bit RGB values and the horizontal and vertical display-size registers. A bus write is single-cycle. It carries a byte address, a data word and a byte-enable mask. Each enabled byte lane acts as its own byte write, so a halfword or word access behaves as a run of byte writes.

The colour table uses an 8-byte stride per entry. Only the first three bytes of each stride hold data. The display sizes are not written as whole words. Each size register is assembled from byte writes that land at fixed bit positions, and every bit that such a write does not cover keeps its value. Control-space reads always return zero.

Each write cycle raises a one-cycle refresh request, whether or not the address decoded. The scanout path reads the colour table through a separate index port with one cycle of latency.

Top module: `pal_geom_regs`

## Requirements
- R1: Only the 16-bit offset `addr` is decoded. In a write cycle, byte lane i is active when `byte_en[i]` is 1. It writes `wdata[8i+7:8i]` to offset `addr + i`, taken modulo 2^16, so lower offsets take lower data bytes (little-endian).
- R2: An offset below 0x0800 selects colour entry offset[10:3] and component offset[2:0]. Components 0, 1 and 2 write red, green and blue. Components 3 to 7 change nothing.
- R3: A byte written to offset 0x0918 goes to `disp_width[9:2]`. A byte written to 0x0919 goes to `disp_width[17:10]`. All other width bits keep their value.
- R4: A byte written to offset 0x0940 puts its bits [7:1] into `disp_height[6:0]`. A byte written to 0x0941 goes to `disp_height[14:7]`. All other height bits keep their value.
- R5: A write to an offset at or above 0x0800 other than the four size offsets changes neither the colour table nor the size registers.
- R6: `rdata` is zero in every cycle.
- R7: `refresh_req` is high for exactly the cycle after each cycle with `wr_en` high, even when no lane is enabled or nothing decodes. It is low after a cycle without a write.
- R8: Reset clears every colour entry, the width, the height, `refresh_req` and `scan_rgb`.
- R9: `scan_rgb` presents the entry selected by `scan_idx` one clock after that index is applied, as {red[23:16], green[15:8], blue[7:0]}.
- R10: Size outputs change only in the cycle after a write that hits a size offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | ADDR_W (16) | Byte offset of lane 0 |
| byte_en | input | DATA_W/8 (4) | Lane enable mask |
| wdata | input | DATA_W (32) | Write data, lane i in bits [8i+7:8i] |
| rdata | output | DATA_W (32) | Read data, always zero |
| refresh_req | output | 1 | One-cycle refresh request after any write |
| scan_idx | input | 8 | Colour entry index for scanout |
| scan_rgb | output | 24 | Registered RGB of the indexed entry |
| disp_width | output | WIDTH_W (18) | Display width register |
| disp_height | output | HEIGHT_W (15) | Display height register |

## Verification
The bench builds the block with its defaults: a 32-bit data path (four lanes), a 16-bit offset, an 18-bit width and a 15-bit height. Four lanes allow several cases. A word write can straddle the two width bytes and spill over ignored bytes below them. A word write can fill one colour entry and also present a fourth component that must be dropped. A two-lane write at 0xFFFF wraps to offset zero and lands on entry 0 red. The 0x0800 offset aliases entry 0 under index bits [10:3], so a missing range check on that offset would corrupt entry 0.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
   localparam int BYTE_W   = 8;
   localparam int IDX_W    = 8;
   localparam int ENTRIES  = 1 << IDX_W;
   localparam int RGB_W    = 3 * BYTE_W;
   localparam int PAL_STRIDE_BITS = 3;

   localparam logic [15:0] OFS_PAL_END  = 16'h0800;
   localparam logic [15:0] OFS_WIDTH_LO = 16'h0918;
   localparam logic [15:0] OFS_WIDTH_HI = 16'h0919;
   localparam logic [15:0] OFS_HEIGHT_LO = 16'h0940;
   localparam logic [15:0] OFS_HEIGHT_HI = 16'h0941;

   typedef enum logic [1:0] {
      CH_RED   = 2'd0,
      CH_GREEN = 2'd1,
      CH_BLUE  = 2'd2
   } chan_e;

   typedef struct packed {
      logic pal;
      logic w_lo;
      logic w_hi;
      logic h_lo;
      logic h_hi;
   } lane_hit_t;
endpackage

// File: rtl/pgr_lane_decode.sv
module pgr_lane_decode
   import pgr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LANE   = 0
) (
   input  logic              act,
   input  logic [ADDR_W-1:0] base,
   output lane_hit_t         hit,
   output logic [IDX_W-1:0]  idx,
   output chan_e             chan
);
   localparam logic [ADDR_W-1:0] LANE_OFS = ADDR_W'(LANE);

   logic [ADDR_W-1:0] ofs;

   always_comb begin
      ofs      = base + LANE_OFS;
      hit      = '0;
      hit.pal  = act && (ofs < ADDR_W'(OFS_PAL_END)) && (ofs[2:0] < 3'd3);
      hit.w_lo = act && (ofs == ADDR_W'(OFS_WIDTH_LO));
      hit.w_hi = act && (ofs == ADDR_W'(OFS_WIDTH_HI));
      hit.h_lo = act && (ofs == ADDR_W'(OFS_HEIGHT_LO));
      hit.h_hi = act && (ofs == ADDR_W'(OFS_HEIGHT_HI));
      idx      = ofs[PAL_STRIDE_BITS +: IDX_W];
      chan     = chan_e'(ofs[1:0]);
   end
endmodule

// File: rtl/pgr_palette.sv
module pgr_palette
   import pgr_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [LANES-1:0]             we,
   input  logic [LANES-1:0][IDX_W-1:0]  idx,
   input  logic [LANES-1:0][1:0]        chan,
   input  logic [LANES-1:0][BYTE_W-1:0] data,
   input  logic [IDX_W-1:0]             rd_idx,
   output logic [RGB_W-1:0]             rd_rgb
);
   logic [BYTE_W-1:0] red_q   [ENTRIES];
   logic [BYTE_W-1:0] green_q [ENTRIES];
   logic [BYTE_W-1:0] blue_q  [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) begin
            red_q[e]   <= '0;
            green_q[e] <= '0;
            blue_q[e]  <= '0;
         end
      end else begin
         for (int l = 0; l < LANES; l++) begin
            if (we[l]) begin
               case (chan[l])
                  CH_RED:   red_q[idx[l]]   <= data[l];
                  CH_GREEN: green_q[idx[l]] <= data[l];
                  CH_BLUE:  blue_q[idx[l]]  <= data[l];
                  default:  ;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_rgb <= '0;
      else        rd_rgb <= {red_q[rd_idx], green_q[rd_idx], blue_q[rd_idx]};
   end
endmodule

// File: rtl/pgr_geometry.sv
module pgr_geometry
   import pgr_pkg::*;
#(
   parameter int LANES    = 4,
   parameter int WIDTH_W  = 18,
   parameter int HEIGHT_W = 15
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  lane_hit_t [LANES-1:0]        hit,
   input  logic [LANES-1:0][BYTE_W-1:0] data,
   output logic [WIDTH_W-1:0]           width_q,
   output logic [HEIGHT_W-1:0]          height_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width_q  <= '0;
         height_q <= '0;
      end else begin
         for (int l = 0; l < LANES; l++) begin
            if (hit[l].w_lo) width_q[9:2]   <= data[l];
            if (hit[l].w_hi) width_q[17:10] <= data[l];
            if (hit[l].h_lo) height_q[6:0]  <= data[l][7:1];
            if (hit[l].h_hi) height_q[14:7] <= data[l];
         end
      end
   end
endmodule

// File: rtl/pal_geom_regs.sv
module pal_geom_regs
   import pgr_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 16,
   parameter int WIDTH_W  = 18,
   parameter int HEIGHT_W = 15
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W/8-1:0]   byte_en,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     rdata,
   output logic                  refresh_req,
   input  logic [IDX_W-1:0]      scan_idx,
   output logic [RGB_W-1:0]      scan_rgb,
   output logic [WIDTH_W-1:0]    disp_width,
   output logic [HEIGHT_W-1:0]   disp_height
);
   localparam int LANES = DATA_W / BYTE_W;

   if (DATA_W % BYTE_W != 0 || LANES < 1 || LANES > 8) begin : g_bad_data_w
      $error("pal_geom_regs: DATA_W must be 8..64 in whole bytes");
   end
   if (ADDR_W != 16) begin : g_bad_addr_w
      $error("pal_geom_regs: ADDR_W must be 16");
   end
   if (WIDTH_W < 18 || HEIGHT_W < 15) begin : g_bad_size_w
      $error("pal_geom_regs: size registers too narrow for their byte fields");
   end

   lane_hit_t [LANES-1:0]        hit;
   logic [LANES-1:0]             pal_we;
   logic [LANES-1:0][IDX_W-1:0]  pal_idx;
   logic [LANES-1:0][1:0]        pal_chan;
   logic [LANES-1:0][BYTE_W-1:0] lane_data;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      chan_e ch;
      pgr_lane_decode #(.ADDR_W(ADDR_W), .LANE(l)) u_dec (
         .act  (wr_en && byte_en[l]),
         .base (addr),
         .hit  (hit[l]),
         .idx  (pal_idx[l]),
         .chan (ch)
      );
      assign pal_chan[l]  = ch;
      assign pal_we[l]    = hit[l].pal;
      assign lane_data[l] = wdata[l*BYTE_W +: BYTE_W];
   end

   pgr_palette #(.LANES(LANES)) u_pal (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (pal_we),
      .idx    (pal_idx),
      .chan   (pal_chan),
      .data   (lane_data),
      .rd_idx (scan_idx),
      .rd_rgb (scan_rgb)
   );

   pgr_geometry #(.LANES(LANES), .WIDTH_W(WIDTH_W), .HEIGHT_W(HEIGHT_W)) u_geo (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .data     (lane_data),
      .width_q  (disp_width),
      .height_q (disp_height)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) refresh_req <= 1'b0;
      else        refresh_req <= wr_en;
   end

   assign rdata = '0;
endmodule

// File: rtl/pgr_checker.sv
module pgr_checker #(
   parameter int ADDR_W   = 16,
   parameter int NB       = 4,
   parameter int WIDTH_W  = 18,
   parameter int HEIGHT_W = 15
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [ADDR_W-1:0]   addr,
   input logic [NB-1:0]       byte_en,
   input logic                refresh_req,
   input logic [WIDTH_W-1:0]  disp_width,
   input logic [HEIGHT_W-1:0] disp_height
);
   localparam logic [NB-1:0] LANE0_ONLY = NB'(1);

   AST_REFRESH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> refresh_req); // R7
   AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !refresh_req); // R7
   AST_SIZE_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(disp_width) && $stable(disp_height))); // R10
   AST_UNDECODED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr >= ADDR_W'(16'h0A00) && addr <= ADDR_W'(16'hFFF0))
      |=> ($stable(disp_width) && $stable(disp_height))); // R5
   AST_WIDTH_LO_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && byte_en == LANE0_ONLY && addr == ADDR_W'(16'h0918))
      |=> (disp_width[17:10] == $past(disp_width[17:10]) &&
           disp_width[1:0] == $past(disp_width[1:0]))); // R3
   AST_HEIGHT_LO_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && byte_en == LANE0_ONLY && addr == ADDR_W'(16'h0940))
      |=> (disp_height[14:7] == $past(disp_height[14:7]))); // R4
endmodule

bind pal_geom_regs pgr_checker #(
   .ADDR_W(ADDR_W), .NB(DATA_W/8), .WIDTH_W(WIDTH_W), .HEIGHT_W(HEIGHT_W)
) u_pgr_checker (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .byte_en(byte_en),
   .refresh_req(refresh_req), .disp_width(disp_width), .disp_height(disp_height)
);

// File: tb/pal_geom_regs_test.sv
`timescale 1ns/1ps
module pal_geom_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] addr = '0;
   logic [3:0]  byte_en = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        refresh_req;
   logic [7:0]  scan_idx = '0;
   logic [23:0] scan_rgb;
   logic [17:0] disp_width;
   logic [14:0] disp_height;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pal_geom_regs uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .byte_en(byte_en),
      .wdata(wdata), .rdata(rdata), .refresh_req(refresh_req),
      .scan_idx(scan_idx), .scan_rgb(scan_rgb),
      .disp_width(disp_width), .disp_height(disp_height)
   );

   typedef struct packed {
      logic [15:0] a;
      logic [3:0]  be;
      logic [31:0] d;
      logic [17:0] w;
      logic [14:0] h;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{16'h0918, 4'b0001, 32'h0000_00AB, 18'h002AC, 15'h0000},
      '{16'h0919, 4'b0001, 32'h0000_0012, 18'h04AAC, 15'h0000},
      '{16'h0940, 4'b0001, 32'h0000_00FF, 18'h04AAC, 15'h007F},
      '{16'h0941, 4'b0001, 32'h0000_0003, 18'h04AAC, 15'h01FF},
      '{16'h0918, 4'b0011, 32'h0000_5634, 18'h158D0, 15'h01FF},
      '{16'h0940, 4'b0011, 32'h0000_8102, 18'h158D0, 15'h4081},
      '{16'h0916, 4'b1111, 32'hCCDD_EEFF, 18'h33374, 15'h4081},
      '{16'h0A00, 4'b1111, 32'hFFFF_FFFF, 18'h33374, 15'h4081},
      '{16'h0918, 4'b0000, 32'h0000_00FF, 18'h33374, 15'h4081},
      '{16'h093F, 4'b0010, 32'h0000_4400, 18'h33374, 15'h40A2}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; byte_en = be; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; byte_en = '0;
   endtask

   task automatic read_entry(input logic [7:0] i, output logic [23:0] rgb);
      @(negedge clk);
      scan_idx = i;
      @(negedge clk);
      rgb = scan_rgb;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [23:0] rgb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      check("R8 width", 32'(disp_width), 32'h0);
      check("R8 height", 32'(disp_height), 32'h0);
      check("R8 refresh", 32'(refresh_req), 32'h0);
      read_entry(8'd7, rgb);
      check("R8 entry7", 32'(rgb), 32'h0);

      // R3 R4 R1 R5 R10 vector table
      for (int v = 0; v < NV; v++) begin
         do_write(VECS[v].a, VECS[v].be, VECS[v].d);
         check("R3 width vec", 32'(disp_width), 32'(VECS[v].w));
         check("R4 height vec", 32'(disp_height), 32'(VECS[v].h));
         check("R7 refresh high", 32'(refresh_req), 32'h1);
         check("R6 rdata", rdata, 32'h0);
         @(negedge clk);
         check("R7 refresh low", 32'(refresh_req), 32'h0);
         check("R10 width held", 32'(disp_width), 32'(VECS[v].w));
      end

      // R2 word write fills entry 5; lane 3 is component 3 and is dropped
      do_write(16'h0028, 4'b1111, 32'h9933_2211);
      read_entry(8'd5, rgb);
      check("R2 R9 entry5", 32'(rgb), 32'h11_22_33);
      // R2 components 4..7 ignored
      do_write(16'h002C, 4'b1111, 32'hFFFF_FFFF);
      read_entry(8'd5, rgb);
      check("R2 ignored comps", 32'(rgb), 32'h11_22_33);
      read_entry(8'd6, rgb);
      check("R2 next entry untouched", 32'(rgb), 32'h0);
      // R1 halfword at last entry: green then blue, red untouched
      do_write(16'h07F9, 4'b0011, 32'h0000_BBAA);
      read_entry(8'd255, rgb);
      check("R1 entry255", 32'(rgb), 32'h00_AA_BB);
      // R1 wrap: lane 1 of 0xFFFF lands at offset 0 (entry 0 red)
      do_write(16'hFFFF, 4'b0010, 32'h0000_7700);
      read_entry(8'd0, rgb);
      check("R1 wrap entry0", 32'(rgb), 32'h77_00_00);
      // R5 offset 0x0800 must not alias entry 0
      do_write(16'h0800, 4'b0001, 32'h0000_0055);
      read_entry(8'd0, rgb);
      check("R5 no alias", 32'(rgb), 32'h77_00_00);
      check("R5 width kept", 32'(disp_width), 32'h33374);

      // R9 one-cycle latency: switch index, old value before edge, new after
      @(negedge clk);
      scan_idx = 8'd5;
      @(posedge clk);
      #1;
      check("R9 latency", 32'(scan_rgb), 32'h11_22_33);

      // R8 mid-run reset
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 width after reset", 32'(disp_width), 32'h0);
      check("R8 height after reset", 32'(disp_height), 32'h0);
      rst_n = 1'b1;
      read_entry(8'd5, rgb);
      check("R8 entry5 cleared", 32'(rgb), 32'h0);
      read_entry(8'd255, rgb);
      check("R8 entry255 cleared", 32'(rgb), 32'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule